// File: doc/BRIEF.md
# Clock Output Power Management Controller

This block decides, cycle by cycle, which clock outputs of a multi-source clock generator may drive their pads and which frequency sources (three PLLs and a reference oscillator) stay powered. It does not make clocks. It receives two active-low control pins, a set of configuration inputs and a slow timebase tick. It returns a tristate enable for each configurable output, a run enable for each PLL, a run enable for the reference oscillator, and a lock indication for each PLL. The always-on 32 kHz output is not handled here and is never gated.

The output-control pin has two modes, chosen by a configuration bit. In the first it only three-states the outputs. In the second it powers down every PLL and the oscillator as well. When a power-down ends, the sources restart and each output stays gated until the lock timer of its own parent PLL runs out. The second pin can act as a suspend request or as bit 2 of the CPU frequency select. As a suspend request it gates a configured set of PLLs and outputs. If the output mask leaves a child output of a suspended PLL enabled, the block suspends that child anyway and raises an error flag.

A four-state machine runs the block. `ST_RUN` is normal operation. `ST_OUT_OFF` holds the outputs in three-state while the sources keep running. `ST_SHUT` powers everything down. `ST_RELOCK` brings the sources back up and waits for the PLLs to lock. The transitions are:
- RUN to OUT_OFF when the pin goes low in output-only mode, and RUN to SHUT when it goes low in shutdown mode.
- OUT_OFF to RUN when the pin is released, and OUT_OFF to SHUT if shutdown mode is selected while the pin is still low.
- SHUT to RELOCK when the pin is released.
- RELOCK to RUN once every running PLL reports lock.
- RELOCK back to SHUT or OUT_OFF, depending on the mode, if the pin goes low again.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: With `cfg_full_shut`=0, a low `shut_oe_n` clears every bit of `out_en` while `pll_en`, `osc_en` and `lock_ok` stay high. When the pin is released the outputs return with no relock wait.
- R2: With `cfg_full_shut`=1, a low `shut_oe_n` clears `out_en`, `pll_en`, `osc_en` and `lock_ok`.
- R3: After a full shutdown ends, `osc_en` and all `pll_en` return to 1. An output whose source code is 3 (reference oscillator) is enabled at once. Any other output stays disabled until `lock_ok` of its parent PLL is high.
- R4: `lock_ok[p]` rises after exactly LOCK ticks of `tick` counted while `pll_en[p]` is high. LOCK is `LOCK_CPU`, `LOCK_UTIL` or `LOCK_SYS` for p = 0, 1, 2. When `pll_en[p]` falls, `lock_ok[p]` falls and the count starts over.
- R5: With `cfg_pin_suspend`=1 and `susp_sel_n` low, every PLL p with `cfg_pll_susp[p]`=1 and every output i with `cfg_out_susp[i]`=1 is disabled. All other enables and `osc_en` are unaffected.
- R6: An output whose parent PLL, given by `cfg_out_src[2i+1:2i]` (0 CPU, 1 utility, 2 system, 3 reference), is set in `cfg_pll_susp` is suspended even if its `cfg_out_susp` bit is 0. `cfg_error` is 1 exactly when at least one such output exists.
- R7: A PLL released from suspend relocks per R4, and its child outputs return only after that PLL's lock.
- R8: With `cfg_pin_suspend`=0, `susp_sel_n` has no effect on any enable and `cpu_sel2` follows the pin level. With `cfg_pin_suspend`=1, `cpu_sel2` is 0.
- R9: Both pins pass through a two-flop synchronizer. A pin change made between edges first affects suspend gating after the second following rising edge, and not after the first.
- R10: After reset all `pll_en` and `osc_en` are 1, `lock_ok` is 0, and only reference-sourced outputs are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse used for lock timing |
| shut_oe_n | input | 1 | Asynchronous active-low output-disable / shutdown pin |
| susp_sel_n | input | 1 | Asynchronous active-low suspend pin, or CPU select bit 2 |
| cfg_full_shut | input | 1 | 1: the shutdown pin also powers down the sources |
| cfg_pin_suspend | input | 1 | 1: the shared pin acts as suspend; 0: it acts as select bit |
| cfg_pll_susp | input | 3 | PLLs gated by suspend (bit 0 CPU, 1 utility, 2 system) |
| cfg_out_susp | input | N_OUT | Outputs gated by suspend |
| cfg_out_src | input | 2*N_OUT | Parent source code for each output, two bits per output |
| out_en | output | N_OUT | Output tristate enables (1 = drive) |
| pll_en | output | 3 | PLL run enables |
| osc_en | output | 1 | Reference oscillator run enable |
| lock_ok | output | 3 | PLL lock timer expired |
| cpu_sel2 | output | 1 | Synchronized select bit 2 when the pin is in select mode |
| cfg_error | output | 1 | Suspend mask left a child of a suspended PLL unsuspended |

## Verification
The assertions assume that `tick` is a single-cycle pulse and that every lock load value is at least 1, so a PLL cannot report lock in the same cycle it is enabled. They also assume that the source codes and suspend masks are held steady while the pins are active, because the parent relationship is taken from the configuration inputs as they stand. The directed tests change configuration only while both pins are inactive. They issue ticks one at a time with several idle cycles between them, and they wait enough cycles after every pin change for the synchronizer to settle before sampling, except in the test that measures that latency on purpose.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
package pm_pkg;
    localparam int PLL_CNT = 3;
    localparam int SRC_W   = 2;
    localparam logic [SRC_W-1:0] SRC_REF = 2'd3;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_OUT_OFF = 2'd1,
        ST_SHUT    = 2'd2,
        ST_RELOCK  = 2'd3
    } pm_state_t;
endpackage

// File: rtl/pm_pin_sync.sv
`timescale 1ns/1ps
module pm_pin_sync #(
    parameter int   WIDTH     = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= {WIDTH{RESET_VAL}};
            pin_sync <= {WIDTH{RESET_VAL}};
        end else begin
            stage1   <= pin_async;
            pin_sync <= stage1;
        end
    end
endmodule

// File: rtl/pm_lock_timer.sv
`timescale 1ns/1ps
module pm_lock_timer #(
    parameter int unsigned LOAD  = 50,
    parameter int          CNT_W = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    output logic locked
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= LOAD_V;
        end else if (!en) begin
            remain <= LOAD_V;
        end else if (tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign locked = en && (remain == '0);

    // R4: lock can only appear on the cycle after a timebase tick
    assert_lock_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(tick));

    // R4: dropping the enable removes lock and restarts the wait
    assert_lock_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !locked);
endmodule

// File: rtl/pm_susp_mask.sv
`timescale 1ns/1ps
module pm_susp_mask
    import pm_pkg::*;
#(
    parameter int N_OUT = 6
) (
    input  logic [PLL_CNT-1:0]     pll_susp,
    input  logic [N_OUT-1:0]       out_susp,
    input  logic [N_OUT*SRC_W-1:0] out_src,
    output logic [N_OUT-1:0]       out_susp_fixed,
    output logic                   mask_error
);
    // index 3 (reference) is never suspended through a PLL
    logic [PLL_CNT:0] parent_off;
    logic [N_OUT-1:0] forced;

    assign parent_off = {1'b0, pll_susp};

    for (genvar i = 0; i < N_OUT; i++) begin : g_fix
        logic [SRC_W-1:0] src;
        assign src            = out_src[SRC_W*i +: SRC_W];
        assign forced[i]      = parent_off[src] && !out_susp[i];
        assign out_susp_fixed[i] = out_susp[i] || parent_off[src];
    end

    assign mask_error = |forced;
endmodule

// File: rtl/clk_pwr_ctrl.sv
`timescale 1ns/1ps
module clk_pwr_ctrl
    import pm_pkg::*;
#(
    parameter int          N_OUT     = 6,
    parameter int unsigned LOCK_CPU  = 50,
    parameter int unsigned LOCK_UTIL = 1,
    parameter int unsigned LOCK_SYS  = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick,
    input  logic                   shut_oe_n,
    input  logic                   susp_sel_n,
    input  logic                   cfg_full_shut,
    input  logic                   cfg_pin_suspend,
    input  logic [2:0]             cfg_pll_susp,
    input  logic [N_OUT-1:0]       cfg_out_susp,
    input  logic [2*N_OUT-1:0]     cfg_out_src,
    output logic [N_OUT-1:0]       out_en,
    output logic [2:0]             pll_en,
    output logic                   osc_en,
    output logic [2:0]             lock_ok,
    output logic                   cpu_sel2,
    output logic                   cfg_error
);
    localparam int unsigned LOCK_MAX_A = (LOCK_CPU > LOCK_UTIL) ? LOCK_CPU : LOCK_UTIL;
    localparam int unsigned LOCK_MAX   = (LOCK_MAX_A > LOCK_SYS) ? LOCK_MAX_A : LOCK_SYS;
    localparam int          CNT_W      = $clog2(LOCK_MAX + 1);

    // ---------------- pin synchronizer ----------------
    logic [1:0] pins_sync;
    logic       shut_lo;
    logic       susp_pin_lo;

    pm_pin_sync #(.WIDTH(2), .RESET_VAL(1'b1)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async ({susp_sel_n, shut_oe_n}),
        .pin_sync  (pins_sync)
    );

    assign shut_lo     = !pins_sync[0];
    assign susp_pin_lo = !pins_sync[1];

    // ---------------- suspend mask repair ----------------
    logic [N_OUT-1:0] out_susp_eff;

    pm_susp_mask #(.N_OUT(N_OUT)) u_mask (
        .pll_susp       (cfg_pll_susp),
        .out_susp       (cfg_out_susp),
        .out_src        (cfg_out_src),
        .out_susp_fixed (out_susp_eff),
        .mask_error     (cfg_error)
    );

    // ---------------- lock timers ----------------
    for (genvar p = 0; p < PLL_CNT; p++) begin : g_lock
        localparam int unsigned LP = (p == 0) ? LOCK_CPU :
                                     (p == 1) ? LOCK_UTIL : LOCK_SYS;
        pm_lock_timer #(.LOAD(LP), .CNT_W(CNT_W)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (pll_en[p]),
            .tick   (tick),
            .locked (lock_ok[p])
        );
    end

    // ---------------- state machine ----------------
    pm_state_t state, state_nx;
    logic      all_locked;

    assign all_locked = &(lock_ok | ~pll_en);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN: begin
                if (shut_lo) state_nx = cfg_full_shut ? ST_SHUT : ST_OUT_OFF;
            end
            ST_OUT_OFF: begin
                if (!shut_lo)          state_nx = ST_RUN;
                else if (cfg_full_shut) state_nx = ST_SHUT;
            end
            ST_SHUT: begin
                if (!shut_lo) state_nx = ST_RELOCK;
            end
            ST_RELOCK: begin
                if (shut_lo)         state_nx = cfg_full_shut ? ST_SHUT : ST_OUT_OFF;
                else if (all_locked) state_nx = ST_RUN;
            end
        endcase
    end

    // ---------------- outputs ----------------
    logic             susp_act;
    logic             sources_on;
    logic             drive_on;
    logic [PLL_CNT:0] src_ready;

    assign src_ready = {1'b1, lock_ok};

    always_comb begin
        susp_act   = cfg_pin_suspend && susp_pin_lo;
        sources_on = (state != ST_SHUT);
        drive_on   = (state == ST_RUN) || (state == ST_RELOCK);
        osc_en     = sources_on;
        cpu_sel2   = cfg_pin_suspend ? 1'b0 : pins_sync[1];
        for (int p = 0; p < PLL_CNT; p++) begin
            pll_en[p] = sources_on && !(susp_act && cfg_pll_susp[p]);
        end
        for (int i = 0; i < N_OUT; i++) begin
            out_en[i] = drive_on && !(susp_act && out_susp_eff[i]) &&
                        src_ready[cfg_out_src[SRC_W*i +: SRC_W]];
        end
    end

    // ---------------- assertions ----------------
    logic [PLL_CNT:0] src_running;
    assign src_running = {osc_en, pll_en};

    for (genvar i = 0; i < N_OUT; i++) begin : g_chk
        // R6: an enabled output never has a stopped parent source
        assert_out_parent_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[i] |-> src_running[cfg_out_src[SRC_W*i +: SRC_W]]);
        // R3: an enabled PLL-derived output always has a locked parent
        assert_out_parent_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_en[i] && cfg_out_src[SRC_W*i +: SRC_W] != SRC_REF) |->
                lock_ok[cfg_out_src[SRC_W*i +: SRC_W]]);
    end

    // R2: with the oscillator off, no PLL runs and no output drives
    assert_osc_off_all_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (pll_en == '0 && out_en == '0));
endmodule

// File: tb/test_clk_pwr_ctrl.sv
`timescale 1ns/1ps
module test_clk_pwr_ctrl;
    localparam int N_OUT = 6;

    logic clk = 1'b0;
    logic rst_n;
    logic tick;
    logic shut_oe_n;
    logic susp_sel_n;
    logic cfg_full_shut;
    logic cfg_pin_suspend;
    logic [2:0] cfg_pll_susp;
    logic [N_OUT-1:0] cfg_out_susp;
    logic [2*N_OUT-1:0] cfg_out_src;
    logic [N_OUT-1:0] out_en;
    logic [2:0] pll_en;
    logic osc_en;
    logic [2:0] lock_ok;
    logic cpu_sel2;
    logic cfg_error;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    clk_pwr_ctrl #(
        .N_OUT(N_OUT), .LOCK_CPU(5), .LOCK_UTIL(2), .LOCK_SYS(3)
    ) i_clk_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .shut_oe_n(shut_oe_n), .susp_sel_n(susp_sel_n),
        .cfg_full_shut(cfg_full_shut), .cfg_pin_suspend(cfg_pin_suspend),
        .cfg_pll_susp(cfg_pll_susp), .cfg_out_susp(cfg_out_susp),
        .cfg_out_src(cfg_out_src),
        .out_en(out_en), .pll_en(pll_en), .osc_en(osc_en),
        .lock_ok(lock_ok), .cpu_sel2(cpu_sel2), .cfg_error(cfg_error)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            idle(2);
        end
    endtask

    // outputs 0,1 on CPU PLL; 2 on utility; 3,4 on system; 5 on reference
    task automatic t_reset;
        rst_n = 1'b0; tick = 1'b0; shut_oe_n = 1'b1; susp_sel_n = 1'b1;
        cfg_full_shut = 1'b0; cfg_pin_suspend = 1'b1;
        cfg_pll_susp = 3'b000; cfg_out_susp = '0;
        cfg_out_src = 12'b11_10_10_01_00_00;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        chk("R10 out_en", 32'(out_en), 32'h20);
        chk("R10 pll_en", 32'(pll_en), 32'h7);
        chk("R10 osc_en", 32'(osc_en), 32'h1);
        chk("R10 lock_ok", 32'(lock_ok), 32'h0);
    endtask

    task automatic t_initial_lock;
        pulse_tick(2);
        chk("R4 utility lock", 32'(lock_ok), 32'h2);
        chk("R4 utility child", 32'(out_en), 32'h24);
        pulse_tick(1);
        chk("R4 system lock", 32'(lock_ok), 32'h6);
        chk("R4 system children", 32'(out_en), 32'h3C);
        pulse_tick(2);
        chk("R4 cpu lock", 32'(lock_ok), 32'h7);
        chk("R4 all outputs", 32'(out_en), 32'h3F);
    endtask

    task automatic t_oe_only;
        cfg_full_shut = 1'b0;
        shut_oe_n = 1'b0; idle(4);
        chk("R1 outputs off", 32'(out_en), 32'h0);
        chk("R1 plls on", 32'(pll_en), 32'h7);
        chk("R1 osc on", 32'(osc_en), 32'h1);
        chk("R1 lock kept", 32'(lock_ok), 32'h7);
        shut_oe_n = 1'b1; idle(4);
        chk("R1 outputs back", 32'(out_en), 32'h3F);
    endtask

    task automatic t_full_shutdown;
        cfg_full_shut = 1'b1;
        shut_oe_n = 1'b0; idle(4);
        chk("R2 outputs off", 32'(out_en), 32'h0);
        chk("R2 plls off", 32'(pll_en), 32'h0);
        chk("R2 osc off", 32'(osc_en), 32'h0);
        chk("R2 lock lost", 32'(lock_ok), 32'h0);
        shut_oe_n = 1'b1; idle(4);
        chk("R3 plls restart", 32'(pll_en), 32'h7);
        chk("R3 osc restart", 32'(osc_en), 32'h1);
        chk("R3 only ref out", 32'(out_en), 32'h20);
        pulse_tick(2);
        chk("R3 utility child", 32'(out_en), 32'h24);
        pulse_tick(1);
        chk("R3 system children", 32'(out_en), 32'h3C);
        pulse_tick(1);
        chk("R3 cpu still waits", 32'(out_en), 32'h3C);
        pulse_tick(1);
        chk("R3 all outputs", 32'(out_en), 32'h3F);
        cfg_full_shut = 1'b0;
    endtask

    task automatic t_sync_latency;
        cfg_out_susp = 6'b000001;
        @(negedge clk) susp_sel_n = 1'b0;
        @(negedge clk);
        chk("R9 no effect after one edge", 32'(out_en), 32'h3F);
        @(negedge clk);
        chk("R9 effect after two edges", 32'(out_en), 32'h3E);
        susp_sel_n = 1'b1; idle(4);
        chk("R9 released", 32'(out_en), 32'h3F);
        cfg_out_susp = '0;
    endtask

    task automatic t_suspend;
        cfg_pll_susp = 3'b010; cfg_out_susp = 6'b101100;
        idle(1);
        chk("R6 legal mask no error", 32'(cfg_error), 32'h0);
        susp_sel_n = 1'b0; idle(4);
        chk("R5 pll_en", 32'(pll_en), 32'h5);
        chk("R5 out_en", 32'(out_en), 32'h13);
        chk("R5 osc_en", 32'(osc_en), 32'h1);
        susp_sel_n = 1'b1; idle(4);
        chk("R7 utility relocking", 32'(lock_ok), 32'h5);
        chk("R7 child waits", 32'(out_en), 32'h3B);
        pulse_tick(1);
        chk("R7 child still waits", 32'(out_en), 32'h3B);
        pulse_tick(1);
        chk("R7 child back", 32'(out_en), 32'h3F);
        cfg_pll_susp = '0; cfg_out_susp = '0;
    endtask

    task automatic t_mask_repair;
        cfg_pll_susp = 3'b001; cfg_out_susp = 6'b000001;
        idle(1);
        chk("R6 error flag", 32'(cfg_error), 32'h1);
        susp_sel_n = 1'b0; idle(4);
        chk("R6 child forced off", 32'(out_en), 32'h3C);
        chk("R6 pll_en", 32'(pll_en), 32'h6);
        susp_sel_n = 1'b1; idle(4);
        pulse_tick(5);
        chk("R7 cpu children back", 32'(out_en), 32'h3F);
        cfg_pll_susp = '0; cfg_out_susp = '0;
        idle(1);
        chk("R6 error clears", 32'(cfg_error), 32'h0);
    endtask

    task automatic t_select_mode;
        cfg_pin_suspend = 1'b0; cfg_pll_susp = 3'b111; cfg_out_susp = 6'h3F;
        susp_sel_n = 1'b0; idle(4);
        chk("R8 outputs untouched", 32'(out_en), 32'h3F);
        chk("R8 plls untouched", 32'(pll_en), 32'h7);
        chk("R8 select low", 32'(cpu_sel2), 32'h0);
        susp_sel_n = 1'b1; idle(4);
        chk("R8 select high", 32'(cpu_sel2), 32'h1);
        cfg_pin_suspend = 1'b1; idle(1);
        chk("R8 select masked in suspend mode", 32'(cpu_sel2), 32'h0);
        cfg_pll_susp = '0; cfg_out_susp = '0;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_initial_lock();
        t_oe_only();
        t_full_shutdown();
        t_sync_latency();
        t_suspend();
        t_mask_repair();
        t_select_mode();
        done = 1;
        finish_run();
    end

    initial begin
        #500000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule